// File: doc/BRIEF.md
# One-Time-Programmable Region Lock Controller

This block holds the one-time-programmable (OTP) page region of a serial flash device together with the bits that guard it. It keeps a byte-addressed OTP array, a volatile configuration register that holds an access enable and two sticky lock bits, and an 8-bit protection register. A command is a one-cycle strobe carrying an opcode, a page index, a byte offset and a data byte. Each command is answered one cycle later with a done pulse and a status: accepted, rejected with an address error, routed to the main array (not OTP), or plainly rejected.

Programming can only clear bits. Erase never restores them. OTP traffic only reaches the region while the access enable is set. The OTP lock freezes the array. The protection lock freezes the protection register, and it can only be taken once both protection-mode bits are set and OTP access is enabled.

The legal address space is 10 pages of 2,112 bytes. Storage is backed for the first `STORE_BYTES` bytes of each page. A build that sets `STORE_BYTES` equal to `PAGE_BYTES` backs every byte.

Top module: `otp_lock_top`

## Requirements
- R1: After power-up reset, `cfgOut` and `protOut` are 00h. Every backed OTP byte reads FFh and `rdData` is FFh.
- R2: Opcode 1 (program) with access enabled, a legal address and no OTP lock stores old AND `wrData` and is accepted. A later read (opcode 2) returns the stored byte. Bits at 0 stay 0 even when a later program writes FFh.
- R3: Opcode 3 (erase) never changes OTP data. It is rejected (`ok`=0, `notOtp`=0) while access is enabled, and it gives `notOtp`=1 while access is disabled.
- R4: Once the OTP lock (`cfgOut` bit 7) is 1, every program is rejected and leaves the data unchanged. A configuration write with bit 7 at 0 does not clear the lock, and neither does a reset command.
- R5: A program or read issued while OTP access enable (`cfgOut` bit 6) is 0 answers `notOtp`=1 with `ok`=0, and it changes no OTP data.
- R6: Opcode 6 (reset command) is accepted, clears `cfgOut` bit 6, and leaves both lock bits and `protOut` unchanged.
- R7: Opcode 4 (configuration write) loads bit 6 of `wrData` into the access enable, and sets bit 7 into the OTP lock and bit 0 into the protection lock. These are the same positions they occupy in `cfgOut`. A request to set the protection lock while it is still 0 is honoured only if `protOut[1:0]` is 2'b11 and the access enable is already 1 before this write. Otherwise the whole write is rejected and nothing changes.
- R8: Opcode 5 (protection write) loads `wrData` into `protOut` while the protection lock (`cfgOut` bit 0) is 0. Once that lock is 1, every protection write is rejected and `protOut` holds. No command clears the protection lock.
- R9: With access enabled, a program or read whose page index is 10 or more, or whose byte offset is 2,112 or more, answers `badAddr`=1 with `ok`=0 and changes nothing. Access enable is checked before the address, and the address before the OTP lock.
- R10: Every command strobe produces `done`=1 exactly one cycle later, for one cycle. At most one of `ok`, `badAddr` and `notOtp` is 1, and only together with `done`. Opcodes 0 and 7 are rejected with no effect.
- R11: A legal offset at or beyond `STORE_BYTES` reads FFh, and a program there is accepted without changing any backed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-up reset, active low |
| cmdValid | input | 1 | One-cycle command strobe |
| cmdOp | input | 3 | Opcode (1 program, 2 read, 3 erase, 4 config write, 5 protection write, 6 reset) |
| pageIdx | input | 4 | OTP page index |
| byteOff | input | 12 | Byte offset within the page |
| wrData | input | 8 | Program data, configuration or protection value |
| done | output | 1 | Command answered this cycle |
| ok | output | 1 | Command accepted |
| badAddr | output | 1 | Rejected for page or offset out of range |
| notOtp | output | 1 | Routed to the main array because OTP access is off |
| rdData | output | 8 | Byte returned by the last accepted read |
| cfgOut | output | 8 | Configuration: bit 7 OTP lock, bit 6 access enable, bit 0 protection lock |
| protOut | output | 8 | Protection register, bits 1:0 are the protection-mode bits |

## Verification
Two things can land in the same configuration write: clearing the access enable and requesting the protection lock. The request must be judged on the access enable held before the write. The bench provokes this with protection mode 2'b11, access enabled, and a single write of 01h. It expects the write to be accepted and `cfgOut` to read 01h, with the lock taken and the enable gone. It also issues the same write with access already off and expects a rejection that leaves `cfgOut` at 00h.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_READ  = 3'd2,
    OP_ERASE = 3'd3,
    OP_CFG   = 3'd4,
    OP_PROT  = 3'd5,
    OP_RESET = 3'd6,
    OP_SPARE = 3'd7
  } cmdOp_e;

  // strobes from control to the storage datapath
  typedef struct packed {
    logic progEn;
    logic readEn;
  } storeCtl_t;

  localparam int CFG_LOCK_BIT = 7;
  localparam int CFG_EN_BIT   = 6;
  localparam int CFG_PROT_BIT = 0;

endpackage

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl
  import otp_lock_pkg::*;
#(
  parameter int PAGES      = 10,
  parameter int PAGE_BYTES = 2112,
  parameter int PAGE_W     = $clog2(PAGES),
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [PAGE_W-1:0] pageIdx,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [7:0]        wrData,
  output storeCtl_t         storeCtl,
  output logic              done,
  output logic              ok,
  output logic              badAddr,
  output logic              notOtp,
  output logic [7:0]        cfgOut,
  output logic [7:0]        protOut
);

  localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(PAGES - 1);
  localparam logic [OFF_W-1:0]  LAST_OFF  = OFF_W'(PAGE_BYTES - 1);

  logic otpEn, otpLock, protLock;
  logic [7:0] protReg;

  logic nxtOk, nxtBad, nxtNot;
  logic nxtEn, nxtLock, nxtProtLock;
  logic [7:0] nxtProt;
  logic addrOk, protReq, protAllowed;
  cmdOp_e op;

  assign op          = cmdOp_e'(cmdOp);
  assign addrOk      = (pageIdx <= LAST_PAGE) && (byteOff <= LAST_OFF);
  assign protReq     = wrData[CFG_PROT_BIT] && !protLock;
  assign protAllowed = otpEn && (protReg[1:0] == 2'b11);

  always_comb begin
    nxtOk       = 1'b0;
    nxtBad      = 1'b0;
    nxtNot      = 1'b0;
    nxtEn       = otpEn;
    nxtLock     = otpLock;
    nxtProtLock = protLock;
    nxtProt     = protReg;
    storeCtl    = '0;
    if (cmdValid) begin
      unique case (op)
        OP_PROG: begin
          if (!otpEn)       nxtNot = 1'b1;
          else if (!addrOk) nxtBad = 1'b1;
          else if (!otpLock) begin
            storeCtl.progEn = 1'b1;
            nxtOk           = 1'b1;
          end
        end
        OP_READ: begin
          if (!otpEn)       nxtNot = 1'b1;
          else if (!addrOk) nxtBad = 1'b1;
          else begin
            storeCtl.readEn = 1'b1;
            nxtOk           = 1'b1;
          end
        end
        OP_ERASE: begin
          // erase never reaches OTP cells
          if (!otpEn) nxtNot = 1'b1;
        end
        OP_CFG: begin
          if (!(protReq && !protAllowed)) begin
            nxtEn       = wrData[CFG_EN_BIT];
            nxtLock     = otpLock | wrData[CFG_LOCK_BIT];
            nxtProtLock = protLock | wrData[CFG_PROT_BIT];
            nxtOk       = 1'b1;
          end
        end
        OP_PROT: begin
          if (!protLock) begin
            nxtProt = wrData;
            nxtOk   = 1'b1;
          end
        end
        OP_RESET: begin
          nxtEn = 1'b0;
          nxtOk = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      otpEn    <= 1'b0;
      otpLock  <= 1'b0;
      protLock <= 1'b0;
      protReg  <= 8'h00;
      done     <= 1'b0;
      ok       <= 1'b0;
      badAddr  <= 1'b0;
      notOtp   <= 1'b0;
    end else begin
      otpEn    <= nxtEn;
      otpLock  <= nxtLock;
      protLock <= nxtProtLock;
      protReg  <= nxtProt;
      done     <= cmdValid;
      ok       <= nxtOk;
      badAddr  <= nxtBad;
      notOtp   <= nxtNot;
    end
  end

  always_comb begin
    cfgOut               = 8'h00;
    cfgOut[CFG_LOCK_BIT] = otpLock;
    cfgOut[CFG_EN_BIT]   = otpEn;
    cfgOut[CFG_PROT_BIT] = protLock;
  end
  assign protOut = protReg;

endmodule

// File: rtl/otp_lock_store.sv
module otp_lock_store
  import otp_lock_pkg::*;
#(
  parameter int PAGES       = 10,
  parameter int STORE_BYTES = 32,
  parameter int PAGE_W      = 4,
  parameter int OFF_W       = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeCtl_t         storeCtl,
  input  logic [PAGE_W-1:0] pageIdx,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  localparam int CELLS   = PAGES * STORE_BYTES;
  localparam int IDX_W   = $clog2(CELLS);
  localparam int STORE_W = (STORE_BYTES > 1) ? $clog2(STORE_BYTES) : 1;
  localparam logic [OFF_W-1:0] STORE_LIM = OFF_W'(STORE_BYTES);

  logic [7:0] cells [CELLS];
  logic [IDX_W-1:0] idx;
  logic backed;

  assign backed = byteOff < STORE_LIM;
  assign idx    = IDX_W'(pageIdx) * IDX_W'(STORE_BYTES)
                + IDX_W'(byteOff[STORE_W-1:0]);

  generate
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cells[c] <= 8'hFF;
        else if (storeCtl.progEn && backed && (idx == IDX_W'(c)))
          cells[c] <= cells[c] & wrData;  // bits only ever clear
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= 8'hFF;
    else if (storeCtl.readEn)
      rdData <= backed ? cells[idx] : 8'hFF;
  end

endmodule

// File: rtl/otp_lock_top.sv
module otp_lock_top
  import otp_lock_pkg::*;
#(
  parameter int PAGES       = 10,
  parameter int PAGE_BYTES  = 2112,
  parameter int STORE_BYTES = 32,
  parameter int PAGE_W      = $clog2(PAGES),
  parameter int OFF_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [PAGE_W-1:0] pageIdx,
  input  logic [OFF_W-1:0]  byteOff,
  input  logic [7:0]        wrData,
  output logic              done,
  output logic              ok,
  output logic              badAddr,
  output logic              notOtp,
  output logic [7:0]        rdData,
  output logic [7:0]        cfgOut,
  output logic [7:0]        protOut
);

  storeCtl_t storeCtl;

  otp_lock_ctrl #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .pageIdx(pageIdx), .byteOff(byteOff), .wrData(wrData),
    .storeCtl(storeCtl), .done(done), .ok(ok), .badAddr(badAddr),
    .notOtp(notOtp), .cfgOut(cfgOut), .protOut(protOut)
  );

  otp_lock_store #(
    .PAGES(PAGES), .STORE_BYTES(STORE_BYTES), .PAGE_W(PAGE_W), .OFF_W(OFF_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .storeCtl(storeCtl), .pageIdx(pageIdx),
    .byteOff(byteOff), .wrData(wrData), .rdData(rdData)
  );

endmodule

// File: rtl/otp_lock_checker.sv
module otp_lock_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic       done,
  input logic       ok,
  input logic       badAddr,
  input logic       notOtp,
  input logic [7:0] cfgOut,
  input logic [7:0] protOut
);

  a_r10_done_follows: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid) |-> done);
  a_r10_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(cmdValid));
  a_r10_one_status: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ok, badAddr, notOtp}) && (!(ok || badAddr || notOtp) || done));
  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgOut[7]) |-> cfgOut[7]);
  a_r8_prot_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgOut[0]) |-> cfgOut[0]);
  a_r8_prot_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgOut[0]) |-> $stable(protOut));
  a_r5_not_otp_cause: assert property (@(posedge clk) disable iff (!rstN)
    notOtp |-> !$past(cfgOut[6]));
  a_r6_reset_clears_en: assert property (@(posedge clk) disable iff (!rstN)
    $past(cmdValid && cmdOp == 3'd6) |-> (!cfgOut[6] && ok));
  a_r7_lock_precond: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgOut[0]) |-> ($past(cfgOut[6]) && $past(protOut[1:0]) == 2'b11));

endmodule

bind otp_lock_top otp_lock_checker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .done(done), .ok(ok), .badAddr(badAddr), .notOtp(notOtp),
  .cfgOut(cfgOut), .protOut(protOut)
);

// File: tb/otp_lock_top_bench.sv
`timescale 1ns/1ps
module otp_lock_top_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [3:0] pageIdx = '0;
  logic [11:0] byteOff = '0;
  logic [7:0] wrData = '0;
  logic done, ok, badAddr, notOtp;
  logic [7:0] rdData, cfgOut, protOut;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  otp_lock_top u_otp_lock_top (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .pageIdx(pageIdx), .byteOff(byteOff), .wrData(wrData),
    .done(done), .ok(ok), .badAddr(badAddr), .notOtp(notOtp),
    .rdData(rdData), .cfgOut(cfgOut), .protOut(protOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one command; outputs are sampled at the negedge after the capturing edge
  task automatic cmd(input logic [2:0] op, input logic [3:0] pg,
                     input logic [11:0] off, input logic [7:0] d);
    @(negedge clk);
    cmdOp = op; pageIdx = pg; byteOff = off; wrData = d; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic expStat(input string req, input logic eOk,
                         input logic eBad, input logic eNot);
    chk(req, "done", done, 1);
    chk(req, "ok", ok, eOk);
    chk(req, "badAddr", badAddr, eBad);
    chk(req, "notOtp", notOtp, eNot);
  endtask

  task automatic t_reset_state;
    chk("R1", "cfg", cfgOut, 8'h00);
    chk("R1", "prot", protOut, 8'h00);
    chk("R1", "rdData", rdData, 8'hFF);
    cmd(3'd2, 0, 0, 0);
    expStat("R5", 0, 0, 1);
    cmd(3'd4, 0, 0, 8'h40);
    expStat("R7", 1, 0, 0);
    chk("R7", "cfg", cfgOut, 8'h40);
    cmd(3'd2, 9, 31, 0);
    expStat("R1", 1, 0, 0);
    chk("R1", "rd p9", rdData, 8'hFF);
    @(negedge clk);
    chk("R10", "done pulse ends", done, 0);
  endtask

  task automatic t_program;
    cmd(3'd1, 2, 5, 8'hA5); expStat("R2", 1, 0, 0);
    cmd(3'd2, 2, 5, 0);     chk("R2", "rd A5", rdData, 8'hA5);
    cmd(3'd1, 2, 5, 8'h3C); expStat("R2", 1, 0, 0);
    cmd(3'd1, 2, 5, 8'hFF);
    cmd(3'd2, 2, 5, 0);     chk("R2", "rd and", rdData, 8'h24);
    cmd(3'd2, 2, 6, 0);     chk("R2", "neighbour", rdData, 8'hFF);
  endtask

  task automatic t_erase;
    cmd(3'd3, 2, 5, 0); expStat("R3", 0, 0, 0);
    cmd(3'd2, 2, 5, 0); chk("R3", "after erase", rdData, 8'h24);
  endtask

  task automatic t_bounds;
    cmd(3'd1, 10, 0, 8'h00);    expStat("R9", 0, 1, 0);
    cmd(3'd2, 0, 2112, 0);      expStat("R9", 0, 1, 0);
    cmd(3'd1, 9, 2111, 8'h00);  expStat("R11", 1, 0, 0);
    cmd(3'd2, 9, 2111, 0);      expStat("R11", 1, 0, 0);
    chk("R11", "unbacked", rdData, 8'hFF);
    cmd(3'd2, 9, 31, 0);        chk("R11", "backed untouched", rdData, 8'hFF);
    cmd(3'd1, 9, 0, 8'h0F);
    cmd(3'd2, 9, 0, 0);         chk("R2", "last page", rdData, 8'h0F);
    cmd(3'd7, 0, 0, 0);         expStat("R10", 0, 0, 0);
    cmd(3'd0, 0, 0, 0);         expStat("R10", 0, 0, 0);
  endtask

  task automatic t_disabled;
    cmd(3'd4, 0, 0, 8'h00);  chk("R5", "cfg", cfgOut, 8'h00);
    cmd(3'd1, 2, 5, 8'h00);  expStat("R5", 0, 0, 1);
    cmd(3'd3, 2, 5, 0);      expStat("R3", 0, 0, 1);
    cmd(3'd4, 0, 0, 8'h40);
    cmd(3'd2, 2, 5, 0);      chk("R5", "data kept", rdData, 8'h24);
  endtask

  task automatic t_prot_lock;
    cmd(3'd5, 0, 0, 8'h01);  expStat("R8", 1, 0, 0);
    cmd(3'd4, 0, 0, 8'h41);  expStat("R7", 0, 0, 0);
    chk("R7", "mode not 11", cfgOut, 8'h40);
    cmd(3'd5, 0, 0, 8'h03);  chk("R8", "prot", protOut, 8'h03);
    cmd(3'd4, 0, 0, 8'h00);
    cmd(3'd4, 0, 0, 8'h01);  expStat("R7", 0, 0, 0);
    chk("R7", "enable was 0", cfgOut, 8'h00);
    cmd(3'd4, 0, 0, 8'h40);
    // same write drops enable and takes lock: judged on old enable
    cmd(3'd4, 0, 0, 8'h01);  expStat("R7", 1, 0, 0);
    chk("R7", "same cycle", cfgOut, 8'h01);
    cmd(3'd5, 0, 0, 8'h00);  expStat("R8", 0, 0, 0);
    chk("R8", "prot held", protOut, 8'h03);
    cmd(3'd4, 0, 0, 8'h40);  chk("R8", "lock kept", cfgOut, 8'h41);
  endtask

  task automatic t_reset_and_lock;
    cmd(3'd6, 0, 0, 0);      expStat("R6", 1, 0, 0);
    chk("R6", "cfg", cfgOut, 8'h01);
    chk("R6", "prot", protOut, 8'h03);
    cmd(3'd4, 0, 0, 8'hC0);  chk("R4", "cfg", cfgOut, 8'hC1);
    cmd(3'd1, 2, 5, 8'h00);  expStat("R4", 0, 0, 0);
    cmd(3'd2, 2, 5, 0);      chk("R4", "data", rdData, 8'h24);
    cmd(3'd6, 0, 0, 0);      chk("R4", "after reset", cfgOut, 8'h81);
    cmd(3'd4, 0, 0, 8'h40);  chk("R4", "no clear", cfgOut, 8'hC1);
    cmd(3'd1, 9, 0, 8'h00);  expStat("R4", 0, 0, 0);
    cmd(3'd2, 9, 0, 0);      chk("R4", "p9 data", rdData, 8'h0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", done, 0);
    rstN = 1'b1;
    t_reset_state();
    t_program();
    t_erase();
    t_bounds();
    t_disabled();
    t_prot_lock();
    t_reset_and_lock();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule